// File: doc/BRIEF.md
# Dual-clock FIFO with programmable flags

This block is a single-direction, 18-bit first-in first-out buffer whose write side and read side run on two unrelated clocks. A producer pushes words on the write clock and a consumer pulls them on the read clock. Each side has its own active-low enable. The depth is a parameter, 256 words by default and 512 for the larger variant.

The block reports its fill level through four active-low status outputs. Empty and almost-empty are timed to the read clock. Full and almost-full are timed to the write clock. Two offset registers set the almost thresholds. They reset to 8 and are loaded on the write clock, but only while the buffer is still unused after reset.

Each pointer carries one extra wrap bit and crosses into the other domain in Gray code through a two-stage synchronizer. Each side computes its word count from its own pointer and the synchronized pointer of the other side. Read data leaves through a registered output word.

Top module: `xfifo_flags`

## Requirements
- R1: While `rst` is high (sampled on each clock), and after it falls until the first write, `empty_n`=0, `aempty_n`=0, `full_n`=1, `afull_n`=1 and `rd_data`=0. Both offsets hold 8.
- R2: Words come out of `rd_data` in the order in which they were accepted on the write side, with their values unchanged.
- R3: `full_n` is low exactly when the buffer holds DEPTH words. A write attempted while `full_n` is low is dropped, and the dropped word never appears at the output.
- R4: `empty_n` is low exactly when the buffer holds 0 words. A read attempted while it is low leaves `rd_data` unchanged and consumes nothing.
- R5: `aempty_n` is low while the word count is less than or equal to the empty offset n, and high when the count exceeds n.
- R6: `afull_n` is low while the word count is at least DEPTH minus the full offset m, and high below that level.
- R7: While `rd_en_n` is high, `rd_data` keeps its value.
- R8: A write with `cfg_we`=1 loads `cfg_data[log2(DEPTH)-1:0]` into the empty offset when `cfg_sel`=0, or into the full offset when `cfg_sel`=1. The upper bits of `cfg_data` are ignored.
- R9: Once a data word has been accepted after reset, writes with `cfg_we`=1 are ignored until the next reset.
- R10: After a word is written into an empty buffer, `empty_n` goes high no later than the third falling read-clock edge after the accepting write-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| wr_en_n | input | 1 | Active-low write enable |
| wr_data | input | 18 | Word to store |
| cfg_we | input | 1 | Offset register write strobe (write clock) |
| cfg_sel | input | 1 | 0 selects the empty offset, 1 selects the full offset |
| cfg_data | input | 18 | Offset value; only the low log2(DEPTH) bits are used |
| full_n | output | 1 | Low when DEPTH words are held (write clock) |
| afull_n | output | 1 | Low at or above DEPTH minus the full offset (write clock) |
| rd_en_n | input | 1 | Active-low read enable |
| rd_data | output | 18 | Registered output word |
| empty_n | output | 1 | Low when no word is held (read clock) |
| aempty_n | output | 1 | Low at or below the empty offset (read clock) |

## Verification
The bench builds the block with DEPTH=32. At that depth the full boundary, the writes dropped when full, and the almost-full band are reached within a few dozen writes, and every fill level can be swept one word at a time. The 5-bit offset field leaves 13 upper bits of `cfg_data` that the bench fills with junk, so that the ignored bits can be seen to have no effect. The clock periods are in a 10:14 ratio, so pointer crossings occur at a drifting phase, and randomized write and read bursts are checked against a word-count model at the default offsets and at reprogrammed ones.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;
    localparam int WORD_W      = 18;
    localparam int OFF_RESET   = 8;
    localparam int SYNC_STAGES = 2;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        OFS_EMPTY = 1'b0,
        OFS_FULL  = 1'b1
    } ofs_sel_e;

    typedef struct packed {
        logic     we;
        ofs_sel_e sel;
        word_t    data;
    } ofs_req_t;
endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
    parameter int W      = 9,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_st
            logic [W-1:0] r;
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) r <= '0;
                    else     r <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) r <= '0;
                    else     r <= g_st[s-1].r;
                end
            end
        end
    endgenerate

    assign q = g_st[STAGES-1].r;
endmodule

// File: rtl/xfifo_mem.sv
module xfifo_mem
    import xfifo_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    word_t store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/xfifo_wside.sv
module xfifo_wside
    import xfifo_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic          wclk,
    input  logic          rst,
    input  logic          wr_en_n,
    input  ofs_req_t      ofs_req,
    input  logic [CW-1:0] rgray_s,
    output logic          wr_fire,
    output logic [AW-1:0] waddr,
    output logic [CW-1:0] wgray,
    output logic [AW-1:0] ae_off,
    output logic          full_n,
    output logic          afull_n
);
    logic [CW-1:0] wbin, wbin_nxt, rbin_s, wcount, af_level;
    logic [AW-1:0] af_off;
    logic          used;
    logic          unused_hi;

    assign unused_hi = ^ofs_req.data[WORD_W-1:AW];

    always_comb begin
        rbin_s[CW-1] = rgray_s[CW-1];
        for (int i = CW - 2; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
    end

    assign wcount   = wbin - rbin_s;
    assign af_level = CW'(DEPTH) - {1'b0, af_off};
    assign full_n   = (wcount != CW'(DEPTH));
    assign afull_n  = (wcount < af_level);
    assign wr_fire  = !wr_en_n && full_n;
    assign wbin_nxt = wbin + CW'(1);
    assign waddr    = wbin[AW-1:0];

    always_ff @(posedge wclk) begin
        if (rst) begin
            wbin   <= '0;
            wgray  <= '0;
            used   <= 1'b0;
            ae_off <= AW'(OFF_RESET);
            af_off <= AW'(OFF_RESET);
        end else begin
            if (wr_fire) begin
                wbin  <= wbin_nxt;
                wgray <= wbin_nxt ^ (wbin_nxt >> 1);
                used  <= 1'b1;
            end
            if (ofs_req.we && !used) begin
                if (ofs_req.sel == OFS_EMPTY) ae_off <= ofs_req.data[AW-1:0];
                else                          af_off <= ofs_req.data[AW-1:0];
            end
        end
    end

    p_no_overflow_r3: assert property (@(posedge wclk) disable iff (rst)
        (wcount == CW'(DEPTH)) |=> $stable(wbin));
    p_wcount_bound_r3: assert property (@(posedge wclk) disable iff (rst)
        wcount <= CW'(DEPTH));
    p_cfg_lock_r9: assert property (@(posedge wclk) disable iff (rst)
        used |=> ($stable(ae_off) && $stable(af_off)));
endmodule

// File: rtl/xfifo_rside.sv
module xfifo_rside
    import xfifo_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic          rclk,
    input  logic          rst,
    input  logic          rd_en_n,
    input  logic [CW-1:0] wgray_s,
    input  logic [AW-1:0] ae_off,
    input  word_t         mem_q,
    output logic [AW-1:0] raddr,
    output logic [CW-1:0] rgray,
    output word_t         rd_data,
    output logic          empty_n,
    output logic          aempty_n
);
    logic [CW-1:0] rbin, rbin_nxt, wbin_s, rcount;
    logic          rd_fire;

    always_comb begin
        wbin_s[CW-1] = wgray_s[CW-1];
        for (int i = CW - 2; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
    end

    assign rcount   = wbin_s - rbin;
    assign empty_n  = (rcount != '0);
    assign aempty_n = (rcount > {1'b0, ae_off});
    assign rd_fire  = !rd_en_n && empty_n;
    assign rbin_nxt = rbin + CW'(1);
    assign raddr    = rbin[AW-1:0];

    always_ff @(posedge rclk) begin
        if (rst) begin
            rbin    <= '0;
            rgray   <= '0;
            rd_data <= '0;
        end else if (rd_fire) begin
            rbin    <= rbin_nxt;
            rgray   <= rbin_nxt ^ (rbin_nxt >> 1);
            rd_data <= mem_q;
        end
    end

    p_no_underrun_r4: assert property (@(posedge rclk) disable iff (rst)
        (rcount == '0) |=> $stable(rbin));
    p_empty_hold_r4: assert property (@(posedge rclk) disable iff (rst)
        (rcount == '0) |=> $stable(rd_data));
    p_rcount_bound_r2: assert property (@(posedge rclk) disable iff (rst)
        rcount <= CW'(DEPTH));
    p_hold_r7: assert property (@(posedge rclk) disable iff (rst)
        rd_en_n |=> $stable(rd_data));
endmodule

// File: rtl/xfifo_flags.sv
module xfifo_flags
    import xfifo_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic        wclk,
    input  logic        rclk,
    input  logic        rst,
    input  logic        wr_en_n,
    input  logic [17:0] wr_data,
    input  logic        cfg_we,
    input  logic        cfg_sel,
    input  logic [17:0] cfg_data,
    output logic        full_n,
    output logic        afull_n,
    input  logic        rd_en_n,
    output logic [17:0] rd_data,
    output logic        empty_n,
    output logic        aempty_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [CW-1:0] wgray, rgray, wgray_s, rgray_s;
    logic [AW-1:0] waddr, raddr, ae_off;
    logic          wr_fire;
    word_t         mem_q;
    ofs_req_t      ofs_req;

    assign ofs_req.we   = cfg_we;
    assign ofs_req.sel  = ofs_sel_e'(cfg_sel);
    assign ofs_req.data = cfg_data;

    xfifo_wside #(.DEPTH(DEPTH)) wside_i (
        .wclk(wclk), .rst(rst), .wr_en_n(wr_en_n), .ofs_req(ofs_req),
        .rgray_s(rgray_s), .wr_fire(wr_fire), .waddr(waddr), .wgray(wgray),
        .ae_off(ae_off), .full_n(full_n), .afull_n(afull_n)
    );

    xfifo_mem #(.DEPTH(DEPTH)) mem_i (
        .wclk(wclk), .we(wr_fire), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_q)
    );

    xfifo_sync #(.W(CW), .STAGES(SYNC_STAGES)) w2r_i (
        .clk(rclk), .rst(rst), .d(wgray), .q(wgray_s)
    );

    xfifo_sync #(.W(CW), .STAGES(SYNC_STAGES)) r2w_i (
        .clk(wclk), .rst(rst), .d(rgray), .q(rgray_s)
    );

    xfifo_rside #(.DEPTH(DEPTH)) rside_i (
        .rclk(rclk), .rst(rst), .rd_en_n(rd_en_n), .wgray_s(wgray_s),
        .ae_off(ae_off), .mem_q(mem_q), .raddr(raddr), .rgray(rgray),
        .rd_data(rd_data), .empty_n(empty_n), .aempty_n(aempty_n)
    );
endmodule

// File: tb/xfifo_flags_tb_top.sv
module xfifo_flags_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RCLK_PERIOD = CLK_PERIOD * 7 / 5;
    localparam int D = 32;

    logic        wclk = 1'b0, rclk = 1'b0, rst = 1'b1;
    logic        wr_en_n = 1'b1, rd_en_n = 1'b1;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [17:0] wr_data = '0, cfg_data = '0;
    logic        full_n, afull_n, empty_n, aempty_n;
    logic [17:0] rd_data;

    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;
    logic [17:0] q[$];
    logic [17:0] last_rd = '0;
    int          ae_exp = 8, af_exp = 8;

    always #(CLK_PERIOD/2) wclk = ~wclk;
    always #(RCLK_PERIOD/2) rclk = ~rclk;

    xfifo_flags #(.DEPTH(D)) dut_i (
        .wclk(wclk), .rclk(rclk), .rst(rst), .wr_en_n(wr_en_n), .wr_data(wr_data),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .full_n(full_n), .afull_n(afull_n), .rd_en_n(rd_en_n), .rd_data(rd_data),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_aempty_n(input int n); return n > ae_exp; endfunction
    function automatic bit exp_afull_n(input int n);  return n < (D - af_exp); endfunction

    task automatic settle();
        repeat (6) @(negedge rclk);
        repeat (6) @(negedge wclk);
    endtask

    task automatic check_flags();
        int n = q.size();
        check(empty_n == (n != 0), "R4 empty_n", empty_n, n != 0);
        check(aempty_n == exp_aempty_n(n), "R5 aempty_n", aempty_n, exp_aempty_n(n));
        check(full_n == (n != D), "R3 full_n", full_n, n != D);
        check(afull_n == exp_afull_n(n), "R6 afull_n", afull_n, exp_afull_n(n));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) @(negedge rclk);
        repeat (4) @(negedge wclk);
        check(empty_n == 1'b0 && aempty_n == 1'b0, "R1 low flags", {empty_n, aempty_n}, 0);
        check(full_n == 1'b1 && afull_n == 1'b1, "R1 high flags", {full_n, afull_n}, 3);
        rst = 1'b0;
        repeat (3) @(negedge rclk);
        check(rd_data == '0, "R1 rd_data", rd_data, 0);
        q.delete();
        last_rd = '0;
        ae_exp = 8;
        af_exp = 8;
    endtask

    task automatic write_one(input logic [17:0] d);
        @(negedge wclk);
        wr_en_n = 1'b0;
        wr_data = d;
        @(negedge wclk);
        wr_en_n = 1'b1;
        if (q.size() < D) q.push_back(d);
    endtask

    task automatic read_one();
        logic [17:0] e;
        @(negedge rclk);
        rd_en_n = 1'b0;
        @(negedge rclk);
        rd_en_n = 1'b1;
        if (q.size() > 0) begin
            e = q.pop_front();
            check(rd_data == e, "R2 order/data", rd_data, e);
            last_rd = e;
        end else begin
            check(rd_data == last_rd, "R4 read while empty", rd_data, last_rd);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [17:0] v);
        @(negedge wclk);
        cfg_we = 1'b1;
        cfg_sel = sel;
        cfg_data = v;
        @(negedge wclk);
        cfg_we = 1'b0;
    endtask

    // Fill one word at a time past full, then drain past empty, checking every level.
    task automatic sweep();
        for (int c = 0; c < D + 2; c++) begin
            write_one(18'($urandom));
            settle();
            check_flags();
        end
        for (int c = 0; c < D + 2; c++) begin
            read_one();
            settle();
            check_flags();
        end
        repeat (3) @(negedge rclk);
        check(rd_data == last_rd, "R7 hold with rd_en_n high", rd_data, last_rd);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R10: first word latency into an empty buffer
        @(negedge wclk);
        wr_en_n = 1'b0;
        wr_data = 18'h2_5A5A;
        @(posedge wclk);
        #1 wr_en_n = 1'b1;
        q.push_back(18'h2_5A5A);
        begin
            int k = 0;
            do begin
                @(negedge rclk);
                k++;
            end while (!empty_n && k < 8);
            check(k <= 3 && empty_n, "R10 first word visible", k, 3);
        end
        read_one();
        settle();
        check_flags();

        // Default offsets (R1 offsets of 8), every fill level
        sweep();

        // R8: program offsets with junk in the upper bits
        do_reset();
        cfg_write(1'b0, 18'h3_FFE3);
        cfg_write(1'b1, 18'h2_A005);
        ae_exp = 3;
        af_exp = 5;
        sweep();

        // R9: offset writes after data has passed are ignored
        cfg_write(1'b0, 18'h0_0014);
        cfg_write(1'b1, 18'h0_0000);
        sweep();

        // Random bursts against the count model at the programmed offsets
        for (int it = 0; it < 16; it++) begin
            int nw = $urandom_range(0, 14);
            int nr = $urandom_range(0, 14);
            for (int j = 0; j < nw; j++) write_one(18'($urandom));
            settle();
            check_flags();
            for (int j = 0; j < nr; j++) read_one();
            settle();
            check_flags();
        end

        // Random bursts again at default offsets after a fresh reset
        do_reset();
        for (int it = 0; it < 10; it++) begin
            int nw = $urandom_range(0, 20);
            int nr = $urandom_range(0, 20);
            for (int j = 0; j < nw; j++) write_one(18'($urandom));
            settle();
            check_flags();
            for (int j = 0; j < nr; j++) read_one();
            settle();
            check_flags();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual no completion, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule